// File: doc/BRIEF.md
# Serial EEPROM Slave with Page Buffer

This block is the bus-facing front end of a 256-byte serial EEPROM that sits on a two-wire I2C bus. It recognises START and STOP conditions. It accepts transfers only for its own 7-bit device address, which is the prefix 1010 followed by three select bits set by a parameter. After the device address it takes a one-byte word address. Write data goes into a 16-entry page buffer. The buffer is indexed by the low four bits of the address pointer, and a per-entry valid mask records which entries hold data.

When STOP ends a write, the block starts a timed internal write cycle. During that cycle it copies only the buffered entries into the selected page of the array. Until the cycle ends, the block gives no acknowledge to its own device address, so a host can poll for completion. Reads come in three forms: from the current pointer, from a word address sent just before a repeated START, and sequential reads that continue while the host acknowledges. A write-protect input blocks every write.

The bus pins are open-drain style. Each line has a separate input, and the slave pulls SDA low by raising an output enable. The input lines are synchronised to the system clock, which must run much faster than SCL.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: The slave acknowledges a device address byte only when its upper seven bits equal 1010 followed by the DEV_SEL parameter (bit 0 is R/W, where 1 means read). For any other address it drives nothing and ignores the bus until the next START.
- R2: After the device address (R/W=0) and the word address, the slave acknowledges every data byte. Each byte goes to the buffer entry given by the low four pointer bits, and only those bits then increment. The upper four bits, which select the page, stay fixed.
- R3: If more than 16 data bytes arrive in one write, the in-page index wraps from 15 to 0. Later bytes replace the earlier bytes at the same index.
- R4: The array changes only after STOP ends a write. Only the buffered entries are written into the page, and the other bytes of that page keep their old values.
- R5: For WRITE_CYCLES clocks after a committing STOP, the slave does not acknowledge its device address. After that window it acknowledges again.
- R6: With wp_i high, the slave acknowledges the device address and the word address. It does not acknowledge the first data byte, the array is unchanged, and no write cycle starts.
- R7: Random read: a word address, then a repeated START and a read device address, returns the byte stored at that word address. The slave sends data MSB first.
- R8: A current-address read starts at the address one past the last byte accessed.
- R9: A sequential read returns consecutive bytes while the host acknowledges. The pointer steps across the full 8-bit range and wraps from 0xFF to 0x00. A host NACK ends the read.
- R10: A START that arrives during a write discards the buffered bytes. A STOP after that START commits nothing and starts no write cycle.
- R11: After reset the slave releases SDA, is not busy, and every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| wp_i | input | 1 | Write protect, high blocks all writes |
| sda_oe | output | 1 | High pulls SDA low |

## Verification
The assertions check, on every cycle, properties that hold in any bus state:
- The SDA drive changes only while SCL is low.
- No acknowledge is given while a write cycle is running.
- The page bits of the pointer stay fixed when a data byte is buffered.
- The mask empties at every START.
- A commit starts only when the slave is idle and always raises busy.

Only the bench scenarios can show the end-to-end outcomes:
- which array bytes change after a page write that wraps or fills the page only partly;
- that a write-protected or aborted write leaves the page as it was;
- that the host's poll is refused for a while and then accepted;
- that the read pointer carries across page and array boundaries.

// File: rtl/eeprom_pkg.sv
// Shared types and constants for the serial EEPROM slave.
package eeprom_pkg;
    // Transfer phase of the bus-side state machine
    typedef enum logic [3:0] {
        PH_IDLE,
        PH_DEV,
        PH_DEV_ACK,
        PH_WADDR,
        PH_WADDR_ACK,
        PH_WDATA,
        PH_WDATA_ACK,
        PH_RDATA,
        PH_RACK
    } phase_t;

    // Fixed upper nibble of the 7-bit device address
    localparam logic [3:0] DEV_PREFIX = 4'b1010;
endpackage

// File: rtl/i2c_line_sync.sv
// Synchronises SCL and SDA into the clock domain and derives single-cycle
// pulses for SCL edges and for START/STOP conditions.
// Assumes: the system clock is many times faster than SCL, SYNC_STAGES >= 2,
// and the bus idles high.
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_ff;
    logic [SYNC_STAGES-1:0] sda_ff;
    logic                   scl_d;
    logic                   sda_d;

    // Synchroniser chains plus one delayed copy of each line for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
            scl_d  <= scl_ff[SYNC_STAGES-1];
            sda_d  <= sda_ff[SYNC_STAGES-1];
        end
    end

    assign scl_s = scl_ff[SYNC_STAGES-1];
    assign sda_s = sda_ff[SYNC_STAGES-1];

    // Edge and bus-condition pulses
    always_comb begin
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/eeprom_page_buf.sv
// Page write buffer: one data register and one valid flag per in-page slot.
// Assumes: clr has priority over we; the data is read back by slot index
// during the array's write cycle.
module eeprom_page_buf #(
    parameter int PAGE_W = 4,
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          we,
    input  logic [PAGE_W-1:0]             widx,
    input  logic [DATA_W-1:0]             wdata,
    input  logic [PAGE_W-1:0]             ridx,
    output logic [DATA_W-1:0]             rdata,
    output logic [(1<<PAGE_W)-1:0]        mask
);
    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [PAGE_BYTES-1:0][DATA_W-1:0] slots;

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        logic [DATA_W-1:0] q;
        logic              v;

        // One slot: capture data on its own index, flag it valid, clear on START
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
                v <= 1'b0;
            end else if (clr) begin
                v <= 1'b0;
            end else if (we && (widx == PAGE_W'(g))) begin
                q <= wdata;
                v <= 1'b1;
            end
        end

        assign slots[g] = q;
        assign mask[g]  = v;
    end

    assign rdata = slots[ridx];

    AST_MASK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (mask == '0)); // R10
    AST_SLOT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !clr) |=> mask[$past(widx)]); // R2
endmodule

// File: rtl/eeprom_core_array.sv
// Storage array with a timed write cycle. On commit it latches the page
// number and the valid mask, raises busy for WRITE_CYCLES clocks, and during
// the first PAGE_BYTES clocks copies each valid buffer slot into the page.
// Assumes: WRITE_CYCLES >= 2**PAGE_W; the buffer data stays still while busy.
module eeprom_core_array #(
    parameter int ADDR_W       = 8,
    parameter int PAGE_W       = 4,
    parameter int DATA_W       = 8,
    parameter int WRITE_CYCLES = 500000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       commit,
    input  logic [ADDR_W-PAGE_W-1:0]   commit_page,
    input  logic [(1<<PAGE_W)-1:0]     commit_mask,
    output logic [PAGE_W-1:0]          buf_idx,
    input  logic [DATA_W-1:0]          buf_data,
    input  logic [ADDR_W-1:0]          raddr,
    output logic [DATA_W-1:0]          rdata,
    output logic                       busy
);
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int CNT_W      = $clog2(WRITE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WRITE_CYCLES - 1);
    localparam logic [CNT_W-1:0] CNT_PAGE = CNT_W'(PAGE_BYTES);

    logic [DATA_W-1:0]        mem [DEPTH];
    logic [CNT_W-1:0]         cyc;
    logic [PAGE_BYTES-1:0]    mask_l;
    logic [ADDR_W-PAGE_W-1:0] page_l;
    logic                     drain_we;

    // Write-cycle timer and latched commit context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cyc    <= '0;
            mask_l <= '0;
            page_l <= '0;
        end else if (commit) begin
            busy   <= 1'b1;
            cyc    <= '0;
            mask_l <= commit_mask;
            page_l <= commit_page;
        end else if (busy) begin
            cyc <= cyc + 1'b1;
            if (cyc == CNT_LAST) begin
                busy <= 1'b0;
            end
        end
    end

    assign buf_idx  = cyc[PAGE_W-1:0];
    assign drain_we = busy && (cyc < CNT_PAGE) && mask_l[buf_idx];

    // Array contents: erased at reset, one valid slot copied per clock while draining
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '1;
            end
        end else if (drain_we) begin
            mem[{page_l, buf_idx}] <= buf_data;
        end
    end

    assign rdata = mem[raddr];

    AST_COMMIT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> !busy); // R5
    AST_BUSY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> busy); // R4
endmodule

// File: rtl/i2c_eeprom_slave.sv
// Bus-side state machine of the serial EEPROM slave. It decodes the device
// address and the word address, fills the page buffer, starts a write cycle
// on STOP, and shifts read data out MSB first.
// Assumes: inputs are open-drain line levels, sda_oe high pulls SDA low, and
// the clock runs much faster than SCL.
module i2c_eeprom_slave #(
    parameter logic [2:0] DEV_SEL      = 3'b000,
    parameter int         ADDR_W       = 8,
    parameter int         PAGE_W       = 4,
    parameter int         WRITE_CYCLES = 500000,
    parameter int         SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    output logic sda_oe
);
    import eeprom_pkg::*;

    localparam int DATA_W     = 8;
    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic                  scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    phase_t                phase;
    logic [3:0]            bit_cnt;
    logic [DATA_W-1:0]     shreg;
    logic [ADDR_W-1:0]     ptr;
    logic                  rw;
    logic                  in_write;
    logic                  busy;
    logic                  buf_we;
    logic                  commit;
    logic                  byte_done;
    logic                  dev_match;
    logic [PAGE_BYTES-1:0] mask;
    logic [PAGE_W-1:0]     drain_idx;
    logic [DATA_W-1:0]     drain_data;
    logic [DATA_W-1:0]     rd_byte;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    eeprom_page_buf #(.PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start_det),
        .we    (buf_we),
        .widx  (ptr[PAGE_W-1:0]),
        .wdata (shreg),
        .ridx  (drain_idx),
        .rdata (drain_data),
        .mask  (mask)
    );

    eeprom_core_array #(
        .ADDR_W       (ADDR_W),
        .PAGE_W       (PAGE_W),
        .DATA_W       (DATA_W),
        .WRITE_CYCLES (WRITE_CYCLES)
    ) u_array (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit      (commit),
        .commit_page (ptr[ADDR_W-1:PAGE_W]),
        .commit_mask (mask),
        .buf_idx     (drain_idx),
        .buf_data    (drain_data),
        .raddr       (ptr),
        .rdata       (rd_byte),
        .busy        (busy)
    );

    // Decode of byte boundaries, device address match, buffer write and commit
    always_comb begin
        byte_done = scl_fall && (bit_cnt == 4'd8) && !start_det && !stop_det;
        dev_match = (shreg[7:1] == {DEV_PREFIX, DEV_SEL});
        buf_we    = byte_done && (phase == PH_WDATA) && !wp_i;
        commit    = stop_det && in_write && (|mask);
    end

    // Main transfer state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            ptr      <= '0;
            rw       <= 1'b0;
            in_write <= 1'b0;
            sda_oe   <= 1'b0;
        end else if (start_det) begin
            phase    <= PH_DEV;
            bit_cnt  <= '0;
            in_write <= 1'b0;
            sda_oe   <= 1'b0;
        end else if (stop_det) begin
            phase    <= PH_IDLE;
            in_write <= 1'b0;
            sda_oe   <= 1'b0;
        end else begin
            case (phase)
                PH_DEV, PH_WADDR, PH_WDATA: begin
                    if (scl_rise && (bit_cnt != 4'd8)) begin
                        shreg   <= {shreg[DATA_W-2:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (byte_done) begin
                        if (phase == PH_DEV) begin
                            if (dev_match && !busy) begin
                                rw     <= shreg[0];
                                sda_oe <= 1'b1;
                                phase  <= PH_DEV_ACK;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end else if (phase == PH_WADDR) begin
                            ptr      <= shreg;
                            in_write <= 1'b1;
                            sda_oe   <= 1'b1;
                            phase    <= PH_WADDR_ACK;
                        end else if (wp_i) begin
                            in_write <= 1'b0;
                            phase    <= PH_IDLE;
                        end else begin
                            ptr    <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
                            sda_oe <= 1'b1;
                            phase  <= PH_WDATA_ACK;
                        end
                    end
                end
                PH_DEV_ACK: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (rw) begin
                            shreg  <= rd_byte;
                            ptr    <= ptr + 1'b1;
                            sda_oe <= ~rd_byte[DATA_W-1];
                            phase  <= PH_RDATA;
                        end else begin
                            sda_oe <= 1'b0;
                            phase  <= PH_WADDR;
                        end
                    end
                end
                PH_WADDR_ACK, PH_WDATA_ACK: begin
                    if (scl_fall) begin
                        sda_oe  <= 1'b0;
                        bit_cnt <= '0;
                        phase   <= PH_WDATA;
                    end
                end
                PH_RDATA: begin
                    if (scl_fall) begin
                        if (bit_cnt == 4'd7) begin
                            sda_oe <= 1'b0;
                            phase  <= PH_RACK;
                        end else begin
                            shreg   <= {shreg[DATA_W-2:0], 1'b0};
                            sda_oe  <= ~shreg[DATA_W-2];
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                    end
                end
                PH_RACK: begin
                    if (scl_rise && sda_s) begin
                        phase <= PH_IDLE;
                    end else if (scl_fall) begin
                        shreg   <= rd_byte;
                        ptr     <= ptr + 1'b1;
                        sda_oe  <= ~rd_byte[DATA_W-1];
                        bit_cnt <= '0;
                        phase   <= PH_RDATA;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s); // R7
    AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DEV_ACK) |-> !busy); // R5
    AST_PAGE_BITS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]))); // R2
endmodule

// File: tb/sim_i2c_eeprom_slave.sv
// Self-checking bench: a bit-level bus master with a behavioural memory model.
module sim_i2c_eeprom_slave;
    localparam int Q      = 10;
    localparam int WCYC   = 3000;
    localparam logic [7:0] DEV_W = 8'hA0;
    localparam logic [7:0] DEV_R = 8'hA1;
    // Vector table: {word address, data} for single-byte write then read back
    localparam logic [15:0] VEC [6] = '{16'h005A, 16'h01A5, 16'h7F3C,
                                        16'h80C3, 16'hFF01, 16'h3EE7};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_low = 1'b0;
    logic wp = 1'b0;
    logic sda_oe;
    logic sda_line;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] model [256];
    logic [7:0] wbuf [32];
    logic [7:0] mptr;

    always #5 clk = ~clk;
    assign sda_line = !(m_low || sda_oe);

    i2c_eeprom_slave #(.DEV_SEL(3'b000), .WRITE_CYCLES(WCYC)) u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (m_scl),
        .sda_i  (sda_line),
        .wp_i   (wp),
        .sda_oe (sda_oe)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; wq(); m_scl = 1'b1; wq(); m_low = 1'b1; wq(); m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wq(); m_scl = 1'b1; wq(); m_low = 1'b0; wq();
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
        end
        m_low = 1'b0; wq(); m_scl = 1'b1; wq(); ack = !sda_line; wq(); m_scl = 1'b0; wq();
    endtask

    task automatic rd_byte(input logic mack, output logic [7:0] d);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wq(); m_scl = 1'b1; wq(); d[i] = sda_line; wq(); m_scl = 1'b0;
        end
        wq(); m_low = mack; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
        m_low = 1'b0;
    endtask

    task automatic page_write(input logic [7:0] a, input int n, input string tag);
        logic ack;
        logic [3:0] lo;
        bus_start();
        wr_byte(DEV_W, ack); chk({tag, " dev ack"}, 16'(ack), 16'd1);
        wr_byte(a, ack);     chk({tag, " addr ack"}, 16'(ack), 16'd1);
        for (int i = 0; i < n; i++) begin
            wr_byte(wbuf[i], ack);
            chk({tag, " data ack"}, 16'(ack), 16'd1);
            lo = a[3:0] + 4'(i);
            model[{a[7:4], lo}] = wbuf[i];
        end
        bus_stop();
        lo = a[3:0] + 4'(n);
        mptr = {a[7:4], lo};
    endtask

    task automatic wait_ready(output int nacks);
        logic ack;
        nacks = 0;
        for (int k = 0; k < 60; k++) begin
            bus_start();
            wr_byte(DEV_W, ack);
            bus_stop();
            if (ack) break;
            nacks++;
        end
    endtask

    task automatic rand_read(input logic [7:0] a, input int n, input string tag);
        logic ack;
        logic [7:0] d;
        bus_start();
        wr_byte(DEV_W, ack); chk({tag, " dev ack"}, 16'(ack), 16'd1);
        wr_byte(a, ack);     chk({tag, " addr ack"}, 16'(ack), 16'd1);
        bus_start();
        wr_byte(DEV_R, ack); chk({tag, " read dev ack"}, 16'(ack), 16'd1);
        for (int i = 0; i < n; i++) begin
            rd_byte(i != n - 1, d);
            chk({tag, " read data"}, 16'(d), 16'(model[8'(a + 8'(i))]));
        end
        bus_stop();
        mptr = a + 8'(n);
    endtask

    task automatic cur_read(input int n, input string tag);
        logic ack;
        logic [7:0] d;
        bus_start();
        wr_byte(DEV_R, ack); chk({tag, " dev ack"}, 16'(ack), 16'd1);
        for (int i = 0; i < n; i++) begin
            rd_byte(i != n - 1, d);
            chk({tag, " data"}, 16'(d), 16'(model[8'(mptr + 8'(i))]));
        end
        bus_stop();
        mptr = mptr + 8'(n);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    // Stimulus
    initial begin
        int nk;
        logic ack;
        for (int i = 0; i < 256; i++) model[i] = 8'hFF;
        mptr = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);

        // R11: released bus, erased array, not busy
        chk("R11 sda released", 16'(sda_oe), 16'd0);
        rand_read(8'h10, 1, "R11");

        // Vector table walk: byte write, poll, random read (R2, R7)
        for (int v = 0; v < 6; v++) begin
            wbuf[0] = VEC[v][7:0];
            page_write(VEC[v][15:8], 1, "R2 vec");
            wait_ready(nk);
            rand_read(VEC[v][15:8], 1, "R7 vec");
        end

        // R5: full page write, poll refused at first then accepted
        for (int i = 0; i < 16; i++) wbuf[i] = 8'(8'h20 + 8'(i));
        page_write(8'h40, 16, "R2 page");
        wait_ready(nk);
        chk("R5 polled nack seen", 16'(nk != 0), 16'd1);
        chk("R5 poll ends", 16'(nk < 20), 16'd1);
        rand_read(8'h40, 16, "R9 page");

        // R3: 20 bytes wrap within the page
        for (int i = 0; i < 20; i++) wbuf[i] = 8'(8'h50 + 8'(i));
        page_write(8'h83, 20, "R3");
        wait_ready(nk);
        rand_read(8'h80, 16, "R3");

        // R4: partial page write keeps the other bytes
        for (int i = 0; i < 16; i++) wbuf[i] = 8'(8'h10 + 8'(3 * i));
        page_write(8'hC0, 16, "R4 fill");
        wait_ready(nk);
        for (int i = 0; i < 3; i++) wbuf[i] = 8'(8'hE0 + 8'(i));
        page_write(8'hC5, 3, "R4 part");
        wait_ready(nk);
        rand_read(8'hC0, 16, "R4");

        // R8: current-address reads continue from the pointer
        rand_read(8'hC4, 1, "R8 setup");
        cur_read(2, "R8");

        // R9: sequential read wraps 0xFF to 0x00, then current read after the NACK
        rand_read(8'hFE, 4, "R9 wrap");
        cur_read(1, "R9 end");

        // R6: write protect refuses the first data byte
        wp = 1'b1;
        bus_start();
        wr_byte(DEV_W, ack); chk("R6 dev ack", 16'(ack), 16'd1);
        wr_byte(8'h42, ack); chk("R6 addr ack", 16'(ack), 16'd1);
        wr_byte(8'h99, ack); chk("R6 data nack", 16'(ack), 16'd0);
        bus_stop();
        wp = 1'b0;
        wait_ready(nk);
        chk("R6 no write cycle", 16'(nk), 16'd0);
        rand_read(8'h40, 4, "R6 unchanged");

        // R10: repeated START during a write discards it
        bus_start();
        wr_byte(DEV_W, ack);
        wr_byte(8'h20, ack);
        wr_byte(8'h11, ack); chk("R10 data ack", 16'(ack), 16'd1);
        wr_byte(8'h22, ack);
        bus_start();
        bus_stop();
        wait_ready(nk);
        chk("R10 no write cycle", 16'(nk), 16'd0);
        rand_read(8'h20, 2, "R10 unchanged");

        // R1: foreign device address is not acknowledged and is ignored
        bus_start();
        wr_byte(8'hA2, ack); chk("R1 foreign nack", 16'(ack), 16'd0);
        wr_byte(8'h30, ack); chk("R1 ignored addr", 16'(ack), 16'd0);
        wr_byte(8'h77, ack); chk("R1 ignored data", 16'(ack), 16'd0);
        bus_stop();
        wait_ready(nk);
        chk("R1 no write cycle", 16'(nk), 16'd0);
        rand_read(8'h30, 1, "R1 unchanged");
        chk("R1 sda released", 16'(sda_oe), 16'd0);

        finish_run();
    end
endmodule